// File: doc/BRIEF.md
# SPI register-access command slave

This block is the host-facing command port of a CAN controller. It is an SPI mode-0 slave (idle clock low, data sampled on the rising SCK edge, MSB first, 8-bit words) that sits in front of a 128-byte register file. Each transaction starts when chip select falls. The first byte is an opcode that selects one of several commands: a plain register write, a plain register read, a masked bit update, a shortcut that loads one of the transmit buffers, a shortcut that streams out one of the receive buffers, or a soft reset that returns the whole file to its power-up contents. When chip select rises, the current command ends.

The CAN engine side uses a simple synchronous register bus: an address, a write strobe, write data and combinational read data. Through this bus it fills the receive buffers and picks up transmit data. The 3-bit operating mode that software asks for in the control register is presented on `mode_o`. The same value is mirrored into the status register one clock after it is written. The SPI pins are oversampled by the system clock through two-stage synchronizers, so SCK must be slow compared with `clk_i`.

Top module: `canspi_port`

## Requirements
- R1: Opcode 0x02, then an address byte, then data bytes, writes each data byte to the addressed register, and the address advances by one for each further byte while chip select stays low.
- R2: Opcode 0x03, then an address byte, drives MISO with the register contents MSB first, starting at the third byte. Each further byte returns the next address.
- R3: Opcode 0x05, then address, mask and data bytes, replaces only the register bits whose mask bit is 1, taking them from the data byte; the other bits keep their value.
- R4: Opcode 0x40 + 2*n, for n in 0..2, writes the bytes that follow to addresses 0x30 + 0x10*n + 1 onward. The byte at 0x30 + 0x10*n is left unchanged.
- R5: Opcode 0x90 + 4*n, for n in 0..1, streams 13 bytes on MISO from addresses 0x60 + 0x10*n + 1 onward, with the first byte placed right after the opcode.
- R6: The single-byte opcode 0xC0 clears every register to 0x00, except the control register, which becomes 0x87. One clock later `mode_o` is 3'b100 and the status register reads 0x80.
- R7: The control register at 0x1F holds the requested mode in bits [7:5] (000 normal, 001 sleep, 010 loopback, 011 listen-only, 100 configuration). The status register at 0x1E is read-only, reads {mode, 5'b00000} and follows a control write one clock later, as does `mode_o`.
- R8: Raising chip select ends the command and discards a partially shifted byte. The next transaction is decoded from its first byte as an opcode.
- R9: An opcode outside this set is ignored: no register changes and MISO stays 0 for the rest of the transaction.
- R10: The internal bus writes a register on `bus_we_i` and reads it combinationally on `bus_rdata_o`. If an SPI write and a bus write hit the same address in the same clock, the SPI data is kept. Writes to different addresses in the same clock both take effect.
- R11: After the asynchronous reset, the control register reads 0x87, the status register reads 0x80 and `mode_o` is 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the SPI pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI serial clock, mode 0 |
| mosi_i | input | 1 | SPI data from host |
| csn_i | input | 1 | SPI chip select, active low |
| miso_o | output | 1 | SPI data to host, 0 while deselected |
| bus_addr_i | input | 7 | Internal bus register address |
| bus_we_i | input | 1 | Internal bus write strobe |
| bus_wdata_i | input | 8 | Internal bus write data |
| bus_rdata_o | output | 8 | Internal bus read data |
| mode_o | output | 3 | Operating mode currently entered |

## Verification
Two functions can fall in the same clock: the commit of an SPI data byte and a write from the internal bus. The bench provokes this by driving the final SCK rise of a data byte on a known clock edge and counting the two synchronizer stages and the edge detector. It then places a one-cycle bus strobe on exactly the commit edge. It checks the result by reading the register back: when the target is shared, the SPI value must be the one that remains; when the targets differ, both values must be present.

// File: rtl/canspi_pkg.sv
package canspi_pkg;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 3;

  localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h02;
  localparam logic [BYTE_W-1:0] OP_READ   = 8'h03;
  localparam logic [BYTE_W-1:0] OP_BITMOD = 8'h05;
  localparam logic [BYTE_W-1:0] OP_TXLOAD = 8'h40;  // + 2*n
  localparam logic [BYTE_W-1:0] OP_RXREAD = 8'h90;  // + 4*n
  localparam logic [BYTE_W-1:0] OP_SRESET = 8'hC0;

  localparam logic [MODE_W-1:0] MODE_CFG = 3'b100;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_WR, ST_RD, ST_MASK, ST_BMD, ST_SKIP
  } dec_st_e;

  typedef enum logic [1:0] {K_RD, K_WR, K_BM} acc_kind_e;
endpackage

// File: rtl/canspi_link.sv
module canspi_link
  import canspi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              csn_i,
  input  logic              ld_i,
  input  logic [BYTE_W-1:0] ld_data_i,
  output logic              cs_act_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              fall_o,
  output logic              miso_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [2:0]        sck_s;
  logic [1:0]        mosi_s;
  logic [1:0]        csn_s;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] sh_q;
  logic [BYTE_W-1:0] tx_q;
  logic              rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_s  <= '0;
      mosi_s <= '0;
      csn_s  <= '1;
    end else begin
      sck_s  <= {sck_s[1:0], sck_i};
      mosi_s <= {mosi_s[0], mosi_i};
      csn_s  <= {csn_s[0], csn_i};
    end
  end

  assign cs_act_o = ~csn_s[1];
  assign rise     = cs_act_o &  sck_s[1] & ~sck_s[2];
  assign fall_o   = cs_act_o & ~sck_s[1] &  sck_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
    end else if (!cs_act_o) begin
      bit_cnt <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
    end else begin
      if (rise) begin
        sh_q    <= {sh_q[BYTE_W-3:0], mosi_s[1]};
        bit_cnt <= (bit_cnt == CNT_W'(BYTE_W-1)) ? '0 : bit_cnt + 1'b1;
      end
      // mode 0: next bit goes out on the falling edge
      if (fall_o) tx_q <= ld_i ? ld_data_i : {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign byte_vld_o = rise && (bit_cnt == CNT_W'(BYTE_W-1));
  assign byte_o     = {sh_q, mosi_s[1]};
  assign miso_o     = cs_act_o & tx_q[BYTE_W-1];
endmodule

// File: rtl/canspi_decode.sv
module canspi_decode
  import canspi_pkg::*;
#(
  parameter int              ADDR_W     = 7,
  parameter int              N_TXB      = 3,
  parameter int              N_RXB      = 2,
  parameter logic [BYTE_W-1:0] TXB_BASE   = 8'h30,
  parameter logic [BYTE_W-1:0] RXB_BASE   = 8'h60,
  parameter logic [BYTE_W-1:0] BUF_STRIDE = 8'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              fall_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              srst_o,
  output logic              ld_o,
  output logic              bm_o,
  output logic [BYTE_W-1:0] mask_o
);
  dec_st_e           st_q;
  acc_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] mask_q;
  logic              ld_q;

  logic              tx_hit, rx_hit;
  logic [ADDR_W-1:0] tx_a, rx_a;

  // buffer shortcuts skip the control byte at offset 0
  always_comb begin
    tx_hit = 1'b0;
    tx_a   = '0;
    for (int n = 0; n < N_TXB; n++) begin
      if (byte_i == OP_TXLOAD + BYTE_W'(2*n)) begin
        tx_hit = 1'b1;
        tx_a   = ADDR_W'(TXB_BASE + BYTE_W'(n) * BUF_STRIDE + BYTE_W'(1));
      end
    end
    rx_hit = 1'b0;
    rx_a   = '0;
    for (int n = 0; n < N_RXB; n++) begin
      if (byte_i == OP_RXREAD + BYTE_W'(4*n)) begin
        rx_hit = 1'b1;
        rx_a   = ADDR_W'(RXB_BASE + BYTE_W'(n) * BUF_STRIDE + BYTE_W'(1));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_CMD;
      kind_q <= K_RD;
      addr_q <= '0;
      mask_q <= '0;
      ld_q   <= 1'b0;
    end else if (!cs_act_i) begin
      st_q <= ST_CMD;
      ld_q <= 1'b0;
    end else begin
      if (fall_i) ld_q <= 1'b0;
      if (byte_vld_i) begin
        unique case (st_q)
          ST_CMD: begin
            if (byte_i == OP_WRITE) begin
              st_q <= ST_ADDR; kind_q <= K_WR;
            end else if (byte_i == OP_READ) begin
              st_q <= ST_ADDR; kind_q <= K_RD;
            end else if (byte_i == OP_BITMOD) begin
              st_q <= ST_ADDR; kind_q <= K_BM;
            end else if (tx_hit) begin
              st_q <= ST_WR; addr_q <= tx_a;
            end else if (rx_hit) begin
              st_q <= ST_RD; addr_q <= rx_a; ld_q <= 1'b1;
            end else begin
              st_q <= ST_SKIP;
            end
          end
          ST_ADDR: begin
            addr_q <= byte_i[ADDR_W-1:0];
            unique case (kind_q)
              K_RD:    begin st_q <= ST_RD; ld_q <= 1'b1; end
              K_WR:    st_q <= ST_WR;
              default: st_q <= ST_MASK;
            endcase
          end
          ST_WR:   addr_q <= addr_q + 1'b1;
          ST_RD:   begin addr_q <= addr_q + 1'b1; ld_q <= 1'b1; end
          ST_MASK: begin mask_q <= byte_i; st_q <= ST_BMD; end
          ST_BMD:  st_q <= ST_SKIP;
          default: st_q <= ST_SKIP;
        endcase
      end
    end
  end

  always_comb begin
    we_o    = 1'b0;
    bm_o    = 1'b0;
    srst_o  = 1'b0;
    wdata_o = byte_i;
    if (byte_vld_i) begin
      if (st_q == ST_WR) we_o = 1'b1;
      if (st_q == ST_BMD) begin
        we_o    = 1'b1;
        bm_o    = 1'b1;
        wdata_o = (rdata_i & ~mask_q) | (byte_i & mask_q);
      end
      if (st_q == ST_CMD && byte_i == OP_SRESET) srst_o = 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign ld_o   = ld_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/canspi_regs.sv
module canspi_regs
  import canspi_pkg::*;
#(
  parameter int                ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h1F,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h1E,
  parameter logic [BYTE_W-1:0] CTRL_RST  = 8'h87
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] spi_addr_i,
  input  logic              spi_we_i,
  input  logic [BYTE_W-1:0] spi_wdata_i,
  input  logic              srst_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] spi_rdata_o,
  output logic [BYTE_W-1:0] bus_rdata_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [MODE_W-1:0] mode_q;

  function automatic logic [BYTE_W-1:0] rst_val(input int idx);
    return (idx == int'(CTRL_ADDR)) ? CTRL_RST : '0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= rst_val(i);
      mode_q <= CTRL_RST[BYTE_W-1 -: MODE_W];
    end else begin
      mode_q <= mem[CTRL_ADDR][BYTE_W-1 -: MODE_W];
      for (int i = 0; i < DEPTH; i++) begin
        if (srst_i) begin
          mem[i] <= rst_val(i);
        end else if (i != int'(STAT_ADDR)) begin
          // SPI port has priority on a shared address
          if (spi_we_i && spi_addr_i == ADDR_W'(i))
            mem[i] <= spi_wdata_i;
          else if (bus_we_i && bus_addr_i == ADDR_W'(i))
            mem[i] <= bus_wdata_i;
        end
      end
    end
  end

  function automatic logic [BYTE_W-1:0] rd(input logic [ADDR_W-1:0] a);
    return (a == STAT_ADDR) ? {mode_q, {(BYTE_W-MODE_W){1'b0}}} : mem[a];
  endfunction

  assign spi_rdata_o = rd(spi_addr_i);
  assign bus_rdata_o = rd(bus_addr_i);
  assign mode_o      = mode_q;
endmodule

// File: rtl/canspi_port.sv
module canspi_port
  import canspi_pkg::*;
#(
  parameter int                ADDR_W     = 7,
  parameter int                N_TXB      = 3,
  parameter int                N_RXB      = 2,
  parameter logic [BYTE_W-1:0] TXB_BASE   = 8'h30,
  parameter logic [BYTE_W-1:0] RXB_BASE   = 8'h60,
  parameter logic [BYTE_W-1:0] BUF_STRIDE = 8'h10,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 7'h1F,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 7'h1E,
  parameter logic [BYTE_W-1:0] CTRL_RST   = 8'h87
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              csn_i,
  output logic              miso_o,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  output logic [MODE_W-1:0] mode_o
);
  logic              cs_act, byte_vld, sck_fall, spi_ld, spi_we, srst, bm_fire;
  logic [BYTE_W-1:0] byte_d, spi_wdata, spi_rdata, bm_mask;
  logic [ADDR_W-1:0] spi_addr;

  canspi_link u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (sck_i),
    .mosi_i     (mosi_i),
    .csn_i      (csn_i),
    .ld_i       (spi_ld),
    .ld_data_i  (spi_rdata),
    .cs_act_o   (cs_act),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_d),
    .fall_o     (sck_fall),
    .miso_o     (miso_o)
  );

  canspi_decode #(
    .ADDR_W(ADDR_W), .N_TXB(N_TXB), .N_RXB(N_RXB),
    .TXB_BASE(TXB_BASE), .RXB_BASE(RXB_BASE), .BUF_STRIDE(BUF_STRIDE)
  ) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_d),
    .fall_i     (sck_fall),
    .rdata_i    (spi_rdata),
    .addr_o     (spi_addr),
    .we_o       (spi_we),
    .wdata_o    (spi_wdata),
    .srst_o     (srst),
    .ld_o       (spi_ld),
    .bm_o       (bm_fire),
    .mask_o     (bm_mask)
  );

  canspi_regs #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR), .CTRL_RST(CTRL_RST)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .spi_addr_i  (spi_addr),
    .spi_we_i    (spi_we),
    .spi_wdata_i (spi_wdata),
    .srst_i      (srst),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .spi_rdata_o (spi_rdata),
    .bus_rdata_o (bus_rdata_o),
    .mode_o      (mode_o)
  );
endmodule

// File: rtl/canspi_port_chk.sv
module canspi_port_chk
  import canspi_pkg::*;
#(
  parameter int                ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h1F
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_act_i,
  input logic              fall_i,
  input logic              ld_i,
  input logic              we_i,
  input logic              srst_i,
  input logic              bm_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic [BYTE_W-1:0] rdata_i,
  input logic [BYTE_W-1:0] mask_i,
  input logic              miso_i,
  input logic [MODE_W-1:0] mode_i
);
  logic loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             loaded_q <= 1'b0;
    else if (!cs_act_i)      loaded_q <= 1'b0;
    else if (fall_i && ld_i) loaded_q <= 1'b1;
  end

  // R7
  mode_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CTRL_ADDR && !srst_i) |=> ##1
      (mode_i == $past(wdata_i[BYTE_W-1 -: MODE_W], 2)));

  // R6
  sreset_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> ##1 (mode_i == MODE_CFG));

  // R3
  bitmod_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bm_i |=> (((rdata_i ^ $past(rdata_i)) & ~$past(mask_i)) == '0));

  // R2
  read_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && ld_i) |=> (!cs_act_i || miso_i == $past(rdata_i[BYTE_W-1])));

  // R9
  idle_miso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loaded_q |-> !miso_i);
endmodule

bind canspi_port canspi_port_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_act_i (cs_act),
  .fall_i   (sck_fall),
  .ld_i     (spi_ld),
  .we_i     (spi_we),
  .srst_i   (srst),
  .bm_i     (bm_fire),
  .addr_i   (spi_addr),
  .wdata_i  (spi_wdata),
  .rdata_i  (spi_rdata),
  .mask_i   (bm_mask),
  .miso_i   (miso_o),
  .mode_i   (mode_o)
);

// File: tb/sim_canspi_port.sv
module sim_canspi_port;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sck = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic       miso;
  logic [6:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] mode;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] txb [16];
  logic [7:0] rxb [16];

  always #4 clk = ~clk;

  canspi_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .mosi_i(mosi), .csn_i(csn),
    .miso_o(miso), .bus_addr_i(bus_addr), .bus_we_i(bus_we),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .mode_o(mode)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic r);
    @(negedge clk); mosi = b;
    repeat (3) @(negedge clk);
    r = miso; sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) spi_bit(b[i], r[i]);
  endtask

  task automatic cs_lo();
    @(negedge clk); csn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic xfer(input int n);
    logic [7:0] r;
    cs_lo();
    for (int k = 0; k < n; k++) begin
      spi_byte(txb[k], r);
      rxb[k] = r;
    end
    cs_hi();
  endtask

  task automatic bus_wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_rd(7'h1F, d); chk("R11 ctrl", d, 8'h87);
    bus_rd(7'h1E, d); chk("R11 status", d, 8'h80);
    chk("R11 mode", {5'b0, mode}, 8'h04);
    txb[0] = 8'h03; txb[1] = 8'h1E; txb[2] = 8'h00;
    xfer(3);
    chk("R2 R11 spi status", rxb[2] & 8'hEE, 8'h80);
  endtask

  task automatic t_write_read();
    logic [7:0] d;
    txb[0] = 8'h02; txb[1] = 8'h10; txb[2] = 8'hA5; txb[3] = 8'h5A; txb[4] = 8'hC3;
    xfer(5);
    bus_rd(7'h10, d); chk("R1 byte0", d, 8'hA5);
    bus_rd(7'h11, d); chk("R1 byte1", d, 8'h5A);
    bus_rd(7'h12, d); chk("R1 byte2", d, 8'hC3);
    txb[0] = 8'h03; txb[1] = 8'h10; txb[2] = 8'h00; txb[3] = 8'h00; txb[4] = 8'h00;
    xfer(5);
    chk("R2 read0", rxb[2], 8'hA5);
    chk("R2 read1", rxb[3], 8'h5A);
    chk("R2 read2", rxb[4], 8'hC3);
  endtask

  task automatic t_bitmod();
    logic [7:0] d;
    bus_wr(7'h20, 8'hF0);
    txb[0] = 8'h05; txb[1] = 8'h20; txb[2] = 8'h3C; txb[3] = 8'hAA;
    xfer(4);
    bus_rd(7'h20, d); chk("R3 bitmod", d, 8'hE8);
  endtask

  task automatic t_txload();
    logic [7:0] d;
    for (int n = 0; n < 3; n++) begin
      txb[0] = 8'h40 + 8'(2*n); txb[1] = 8'hA0 + 8'(n); txb[2] = 8'hB0 + 8'(n);
      xfer(3);
      bus_rd(7'h30 + 7'(16*n), d);     chk("R4 ctrl byte kept", d, 8'h00);
      bus_rd(7'h31 + 7'(16*n), d);     chk("R4 first", d, 8'hA0 + 8'(n));
      bus_rd(7'h32 + 7'(16*n), d);     chk("R4 second", d, 8'hB0 + 8'(n));
    end
  endtask

  task automatic t_rxread();
    for (int i = 1; i <= 13; i++) begin
      bus_wr(7'h60 + 7'(i), 8'h40 + 8'(i));
      bus_wr(7'h70 + 7'(i), 8'hC0 + 8'(i));
    end
    txb[0] = 8'h94;
    for (int k = 1; k < 14; k++) txb[k] = 8'h00;
    xfer(14);
    for (int k = 1; k < 14; k++) chk("R5 rx1 stream", rxb[k], 8'hC0 + 8'(k));
    txb[0] = 8'h90;
    xfer(4);
    for (int k = 1; k < 4; k++) chk("R5 rx0 stream", rxb[k], 8'h40 + 8'(k));
  endtask

  task automatic t_mode();
    logic [7:0] d;
    txb[0] = 8'h02; txb[1] = 8'h1F; txb[2] = 8'h40;
    xfer(3);
    chk("R7 mode loopback", {5'b0, mode}, 8'h02);
    txb[0] = 8'h03; txb[1] = 8'h1E; txb[2] = 8'h00;
    xfer(3);
    chk("R7 status mirror", rxb[2], 8'h40);
    txb[0] = 8'h02; txb[1] = 8'h1F; txb[2] = 8'h60;
    xfer(3);
    txb[0] = 8'h02; txb[1] = 8'h1E; txb[2] = 8'hFF;
    xfer(3);
    bus_rd(7'h1E, d); chk("R7 status read-only", d, 8'h60);
    chk("R7 mode listen", {5'b0, mode}, 8'h03);
  endtask

  task automatic t_unknown();
    logic [7:0] d;
    bus_wr(7'h10, 8'h33);
    txb[0] = 8'h07; txb[1] = 8'h10; txb[2] = 8'h55; txb[3] = 8'hFF;
    xfer(4);
    bus_rd(7'h10, d); chk("R9 no write", d, 8'h33);
    chk("R9 miso0", rxb[1] | rxb[2] | rxb[3], 8'h00);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    logic r;
    cs_lo();
    spi_byte(8'h02, d);
    spi_byte(8'h40, d);
    for (int i = 0; i < 4; i++) spi_bit(1'b1, r);
    cs_hi();
    bus_rd(7'h40, d); chk("R8 partial dropped", d, 8'h00);
    txb[0] = 8'h02; txb[1] = 8'h41; txb[2] = 8'h77;
    xfer(3);
    bus_rd(7'h41, d); chk("R8 fresh opcode", d, 8'h77);
    bus_rd(7'h40, d); chk("R8 neighbour", d, 8'h00);
  endtask

  task automatic collide(input logic [6:0] sa, input logic [7:0] sd,
                         input logic [6:0] ba, input logic [7:0] bd);
    logic [7:0] d;
    logic r;
    cs_lo();
    spi_byte(8'h02, d);
    spi_byte({1'b0, sa}, d);
    for (int i = 7; i >= 1; i--) spi_bit(sd[i], r);
    @(negedge clk); mosi = sd[0];
    repeat (3) @(negedge clk);
    sck = 1'b1;
    // two synchronizer stages, then the commit edge
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = ba; bus_wdata = bd; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    repeat (2) @(negedge clk);
    sck = 1'b0;
    cs_hi();
  endtask

  task automatic t_collide();
    logic [7:0] d;
    collide(7'h50, 8'h99, 7'h50, 8'h11);
    bus_rd(7'h50, d); chk("R10 same addr spi wins", d, 8'h99);
    collide(7'h52, 8'h66, 7'h53, 8'h44);
    bus_rd(7'h52, d); chk("R10 spi side", d, 8'h66);
    bus_rd(7'h53, d); chk("R10 bus side", d, 8'h44);
  endtask

  task automatic t_softreset();
    logic [7:0] d;
    txb[0] = 8'hC0;
    xfer(1);
    bus_rd(7'h10, d); chk("R6 cleared", d, 8'h00);
    bus_rd(7'h31, d); chk("R6 txbuf cleared", d, 8'h00);
    bus_rd(7'h1F, d); chk("R6 ctrl", d, 8'h87);
    bus_rd(7'h1E, d); chk("R6 status", d, 8'h80);
    chk("R6 mode cfg", {5'b0, mode}, 8'h04);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_read();
    t_bitmod();
    t_txload();
    t_rxread();
    t_mode();
    t_unknown();
    t_abort();
    t_collide();
    t_softreset();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule